// File: doc/BRIEF.md
# Quarter-Wave Sine Generator with Second-Order Correction

This block turns an unsigned phase word into a signed sine sample. The two phase MSBs pick the quadrant. One shared quarter-wave table, built when the design elaborates, gives a coarse sine sample and a coarse cosine sample through two read ports in the same cycle. The cosine port reads the same table at the mirrored address. The phase bits below the table index form a small residual angle. A fixed-point constant turns that residual into radians. A second-order Taylor step, written in nested form, then refines the coarse value: `s + d*(c - d*s/2)`. This step needs only two data multipliers.

Both streams use a valid/ready handshake. A phase word is taken on a rising edge where `in_valid` and `in_ready` are both high. A result moves on a rising edge where `out_valid` and `out_ready` are both high. Every pipeline stage advances on the same enable. When `out_valid` is high and `out_ready` is low, the whole pipe holds, `in_ready` drops, and the pending result stays on `out_data`. The block never drops or repeats a result, and results leave in the order the phases arrived.

The full scale is ±(2^(OUT_W-1)-1). A phase of 2^PHASE_W corresponds to one full turn.

Top module: `sine_taylor_gen`

## Requirements
- R1: A phase is accepted on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is high whenever `out_ready` is high or `out_valid` is low.
- R2: With `out_ready` held high, the result for a phase accepted on edge k is on `out_data`, with `out_valid` high, right after edge k+4. At most five phases are ever in flight.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value on the next edge.
- R4: For every 16-bit phase p, the output lies within ±2 of round(32767·sin(2π·p/65536)). The output never leaves the range −32767..32767.
- R5: The output is exactly 0 at phase 0x0000, +32767 at 0x4000, 0 at 0x8000 and −32767 at 0xC000.
- R6: Mirror symmetry: for 0 < k < 0x4000, phase 0x8000−k gives exactly the same output as phase k.
- R7: Odd symmetry with round-half-up: the output for phase k+0x8000 plus the output for phase k is 0 or +1.
- R8: If `in_valid` and `out_ready` are held high, one result leaves per cycle. Results leave in arrival order, and no result appears without an accepted phase.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Phase word present |
| in_ready | output | 1 | Block can take a phase this cycle |
| in_phase | input | PHASE_W | Unsigned phase, full turn = 2^PHASE_W |
| out_valid | output | 1 | Sine sample present |
| out_ready | input | 1 | Downstream takes the sample this cycle |
| out_data | output | OUT_W | Signed sine sample |

## Verification
The checker assumes that the surrounding logic keeps to the handshake. It counts the phases taken in and the results taken out, and expects the difference never to go negative. It also assumes that reset comes before any traffic. The bench drives every input on the falling clock edge and changes `in_phase` only after a transfer. It samples the handshake pair shortly after that falling edge, so every transfer it counts is one the design also sees at the next rising edge. The back-pressure scenario gates `out_ready` and `in_valid` with fixed periodic patterns, so the stalls are legal and still land on every pipeline position.

// File: rtl/sine_pkg.sv
package sine_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // 2.0 raised to a non-negative integer power.
  function automatic real pow2_r(input int e);
    real r;
    r = 1.0;
    for (int i = 0; i < e; i++) r = r * 2.0;
    return r;
  endfunction

  // Sine by power series, used only while elaborating.
  function automatic real series_sin(input real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int n = 1; n < 14; n++) begin
      term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Table entry k of a quarter wave cut into segs segments, scaled by amp.
  function automatic int quarter_entry(input int k, input int segs, input real amp);
    real ang;
    ang = (PI_R / 2.0) * real'(k) / real'(segs);
    return $rtoi(series_sin(ang) * amp + 0.5);
  endfunction

  // Radians per phase LSB, in fixed point with ks fraction bits.
  function automatic int rad_step(input int qbits, input int ks);
    return $rtoi((PI_R / 2.0) / pow2_r(qbits) * pow2_r(ks) + 0.5);
  endfunction

endpackage

// File: rtl/sine_phase_split.sv
module sine_phase_split #(
  parameter int PHASE_W = 16,
  parameter int IDX_W   = 7
) (
  input  logic [PHASE_W-1:0] phase,
  output logic [IDX_W:0]     sin_idx,
  output logic [IDX_W:0]     cos_idx,
  output logic [PHASE_W-3-IDX_W:0] resid,
  output logic               negate
);
  localparam int Q_W = PHASE_W - 2;
  localparam int F_W = Q_W - IDX_W;
  localparam logic [IDX_W:0] TOP_IDX = (IDX_W+1)'(1 << IDX_W);

  logic [1:0]   quad;
  logic [Q_W-1:0] inq;
  logic [Q_W:0] folded;

  always_comb begin
    quad = phase[PHASE_W-1 -: 2];
    inq  = phase[Q_W-1:0];
    // Odd quadrants run backwards through the quarter wave.
    if (quad[0]) folded = (Q_W+1)'(1 << Q_W) - {1'b0, inq};
    else         folded = {1'b0, inq};
    sin_idx = folded[Q_W:F_W];
    cos_idx = TOP_IDX - folded[Q_W:F_W];
    resid   = folded[F_W-1:0];
    negate  = quad[1];
  end
endmodule

// File: rtl/sine_quarter_rom.sv
module sine_quarter_rom #(
  parameter int IDX_W   = 7,
  parameter int TAB_W   = 20,
  parameter int OUT_AMP = 32767,
  parameter int GUARD   = 4
) (
  input  logic [IDX_W:0]           sin_addr,
  input  logic [IDX_W:0]           cos_addr,
  output logic signed [TAB_W-1:0]  sin_q,
  output logic signed [TAB_W-1:0]  cos_q
);
  localparam int  SEGS  = 1 << IDX_W;
  localparam real AMP_R = real'(OUT_AMP) * sine_pkg::pow2_r(GUARD);

  logic signed [TAB_W-1:0] rom [0:SEGS];

  for (genvar g = 0; g <= SEGS; g++) begin : g_ent
    localparam logic signed [TAB_W-1:0] VAL =
      TAB_W'(sine_pkg::quarter_entry(g, SEGS, AMP_R));
    assign rom[g] = VAL;
  end

  // Two independent read ports onto one table.
  assign sin_q = rom[sin_addr];
  assign cos_q = rom[cos_addr];
endmodule

// File: rtl/sine_horner_pipe.sv
module sine_horner_pipe #(
  parameter int TAB_W   = 20,
  parameter int DR_W    = 22,
  parameter int KS      = 28,
  parameter int GUARD   = 4,
  parameter int OUT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     in_v,
  input  logic signed [TAB_W-1:0]  in_s,
  input  logic signed [TAB_W-1:0]  in_c,
  input  logic [DR_W-1:0]          in_dr,
  input  logic                     in_neg,
  output logic                     out_v,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int P_W  = DR_W + TAB_W;
  localparam int M_W  = DR_W + TAB_W + 2;
  localparam int S_W  = TAB_W + 2;
  localparam int OUT_AMP = (1 << (OUT_W - 1)) - 1;
  localparam logic signed [S_W-1:0] HALF = S_W'(1 << (GUARD - 1));
  localparam logic signed [S_W-1:0] LIM_HI = S_W'(OUT_AMP);
  localparam logic signed [S_W-1:0] LIM_LO = -S_W'(OUT_AMP);

  // Stage 2: first multiply, d * s
  logic                    s2_v, s2_neg;
  logic signed [TAB_W-1:0] s2_s, s2_c;
  logic [DR_W-1:0]         s2_dr;
  logic [P_W-1:0]          s2_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_neg <= 1'b0; s2_s <= '0; s2_c <= '0; s2_dr <= '0; s2_p <= '0;
    end else if (en) begin
      s2_v   <= in_v;
      s2_neg <= in_neg;
      s2_s   <= in_s;
      s2_c   <= in_c;
      s2_dr  <= in_dr;
      s2_p   <= P_W'(in_dr) * P_W'($unsigned(in_s));
    end
  end

  // Stage 3: inner term c - d*s/2
  logic [P_W-1:0]          half_p;
  logic signed [TAB_W:0]   inner_c;
  logic                    s3_v, s3_neg;
  logic signed [TAB_W-1:0] s3_s;
  logic [DR_W-1:0]         s3_dr;
  logic signed [TAB_W:0]   s3_inner;

  always_comb begin
    half_p  = s2_p >> (KS + 1);
    inner_c = $signed({s2_c[TAB_W-1], s2_c}) - $signed({1'b0, half_p[TAB_W-1:0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_v <= 1'b0; s3_neg <= 1'b0; s3_s <= '0; s3_dr <= '0; s3_inner <= '0;
    end else if (en) begin
      s3_v     <= s2_v;
      s3_neg   <= s2_neg;
      s3_s     <= s2_s;
      s3_dr    <= s2_dr;
      s3_inner <= inner_c;
    end
  end

  // Stage 4: second multiply, d * inner
  logic                    s4_v, s4_neg;
  logic signed [TAB_W-1:0] s4_s;
  logic signed [M_W-1:0]   s4_q;
  logic signed [DR_W:0]    dr_sg;

  assign dr_sg = $signed({1'b0, s3_dr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s4_v <= 1'b0; s4_neg <= 1'b0; s4_s <= '0; s4_q <= '0;
    end else if (en) begin
      s4_v   <= s3_v;
      s4_neg <= s3_neg;
      s4_s   <= s3_s;
      s4_q   <= M_W'(dr_sg) * M_W'(s3_inner);
    end
  end

  // Stage 5: add, apply sign, round half up, clamp
  logic signed [M_W-1:0] corr_full;
  logic signed [S_W-1:0] sum_v, signed_v, rnd_v, lim_v;

  always_comb begin
    corr_full = s4_q >>> KS;
    sum_v     = S_W'(s4_s) + corr_full[S_W-1:0];
    signed_v  = s4_neg ? -sum_v : sum_v;
    rnd_v     = (signed_v + HALF) >>> GUARD;
    if (rnd_v > LIM_HI)      lim_v = LIM_HI;
    else if (rnd_v < LIM_LO) lim_v = LIM_LO;
    else                     lim_v = rnd_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_data <= '0;
    end else if (en) begin
      out_v    <= s4_v;
      out_data <= lim_v[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/sine_taylor_gen.sv
module sine_taylor_gen #(
  parameter int PHASE_W = 16,
  parameter int OUT_W   = 16,
  parameter int IDX_W   = 7,
  parameter int GUARD   = 4,
  parameter int KS      = 28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [PHASE_W-1:0]       in_phase,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int Q_W     = PHASE_W - 2;
  localparam int F_W     = Q_W - IDX_W;
  localparam int TAB_W   = OUT_W + GUARD;
  localparam int OUT_AMP = (1 << (OUT_W - 1)) - 1;
  localparam int KR      = sine_pkg::rad_step(Q_W, KS);
  localparam int KR_W    = KS - Q_W + 1;
  localparam int DR_W    = F_W + KR_W;

  // One enable for the whole pipe: move unless a result is stuck at the exit.
  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  logic [IDX_W:0]          sin_idx, cos_idx;
  logic [F_W-1:0]          resid;
  logic                    negate;
  logic signed [TAB_W-1:0] sin_q, cos_q;
  logic [DR_W-1:0]         dr_now;

  sine_phase_split #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_split (
    .phase   (in_phase),
    .sin_idx (sin_idx),
    .cos_idx (cos_idx),
    .resid   (resid),
    .negate  (negate)
  );

  sine_quarter_rom #(.IDX_W(IDX_W), .TAB_W(TAB_W), .OUT_AMP(OUT_AMP), .GUARD(GUARD)) u_rom (
    .sin_addr (sin_idx),
    .cos_addr (cos_idx),
    .sin_q    (sin_q),
    .cos_q    (cos_q)
  );

  // Residual phase into radians, fixed point with KS fraction bits.
  assign dr_now = DR_W'(resid) * DR_W'(KR);

  // Stage 1: table read register
  logic                    s1_v, s1_neg;
  logic signed [TAB_W-1:0] s1_s, s1_c;
  logic [DR_W-1:0]         s1_dr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_neg <= 1'b0; s1_s <= '0; s1_c <= '0; s1_dr <= '0;
    end else if (en) begin
      s1_v   <= in_valid;
      s1_neg <= negate;
      s1_s   <= sin_q;
      s1_c   <= cos_q;
      s1_dr  <= dr_now;
    end
  end

  sine_horner_pipe #(.TAB_W(TAB_W), .DR_W(DR_W), .KS(KS), .GUARD(GUARD), .OUT_W(OUT_W)) u_horner (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .in_v     (s1_v),
    .in_s     (s1_s),
    .in_c     (s1_c),
    .in_dr    (s1_dr),
    .in_neg   (s1_neg),
    .out_v    (out_valid),
    .out_data (out_data)
  );
endmodule

// File: rtl/sine_taylor_gen_chk.sv
module sine_taylor_gen_chk #(
  parameter int OUT_W = 16,
  parameter int DEPTH = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_data
);
  localparam int AMP = (1 << (OUT_W - 1)) - 1;

  // Phases taken in but not yet handed out.
  int inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= 0;
    else inflight <= inflight + int'(in_valid && in_ready) - int'(out_valid && out_ready);
  end

  assert_ready_when_drained_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  assert_max_inflight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= DEPTH);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_output_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= AMP) && (out_data >= -AMP));

  assert_no_phantom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight > 0);
endmodule

bind sine_taylor_gen sine_taylor_gen_chk #(.OUT_W(OUT_W), .DEPTH(5)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sine_taylor_gen_tb.sv
module sine_taylor_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_phase = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [15:0] out_data;

  always #4 clk = ~clk;  // 125 MHz

  sine_taylor_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int ph [4096];
  int got [4096];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ideal(input int p);
    real x;
    x = 32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(p) / 65536.0);
    return int'($floor(x + 0.5));
  endfunction

  function automatic int absdiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Streams ph[0..count-1] through the block; mode 1 adds periodic stalls and gaps.
  task automatic stream(input int count, input int mode);
    int tx = 0;
    int rx = 0;
    int cyc = 0;
    bit held = 0;
    int held_val = 0;
    while (rx < count) begin
      @(negedge clk);
      cyc++;
      out_ready = (mode == 0) ? 1'b1 : (((cyc * 7) % 5) < 2);
      in_valid  = (tx < count) && ((mode == 0) || (cyc % 3 != 0));
      in_phase  = (tx < count) ? 16'(ph[tx]) : 16'h0;
      #1;
      if (held) chk(out_valid && (int'(out_data) == held_val), "R3 stall hold", int'(out_data), held_val);
      held = out_valid && !out_ready;
      held_val = int'(out_data);
      if (out_valid && out_ready) begin
        got[rx] = int'(out_data);
        rx++;
      end
      if (in_valid && in_ready) tx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_latency;
    int seen = 0;
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_phase  = 16'h2000;
    #1;
    chk(in_ready == 1'b1, "R1 ready with out_ready high", int'(in_ready), 1);
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      if (out_valid && seen == 0) begin
        seen = j;
        chk(absdiff(int'(out_data), ideal(16'h2000)) <= 2, "R4 latency sample", int'(out_data), ideal(16'h2000));
      end
    end
    chk(seen == 5, "R2 latency in cycles", seen, 5);
  endtask

  task automatic t_exact;
    ph[0] = 16'h0000; ph[1] = 16'h4000; ph[2] = 16'h8000; ph[3] = 16'hC000;
    stream(4, 0);
    chk(got[0] == 0, "R5 phase 0x0000", got[0], 0);
    chk(got[1] == 32767, "R5 phase 0x4000", got[1], 32767);
    chk(got[2] == 0, "R5 phase 0x8000", got[2], 0);
    chk(got[3] == -32767, "R5 phase 0xC000", got[3], -32767);
  endtask

  task automatic t_sweep;
    for (int blk = 0; blk < 16; blk++) begin
      for (int i = 0; i < 4096; i++) ph[i] = blk * 4096 + i;
      stream(4096, 0);
      for (int i = 0; i < 4096; i++) begin
        chk(absdiff(got[i], ideal(ph[i])) <= 2, "R4 sweep accuracy", got[i], ideal(ph[i]));
        chk(got[i] <= 32767 && got[i] >= -32767, "R4 range", got[i], 0);
      end
    end
  endtask

  task automatic t_throughput;
    int start;
    int stop;
    for (int i = 0; i < 64; i++) ph[i] = i * 1021;
    @(negedge clk);
    start = $time;
    stream(64, 0);
    stop = $time;
    // 64 results plus the fill of five stages and the trailing negedge.
    chk((stop - start) / 8 <= 64 + 7, "R8 one result per cycle", (stop - start) / 8, 71);
    for (int i = 0; i < 64; i++)
      chk(absdiff(got[i], ideal(ph[i])) <= 2, "R8 order kept", got[i], ideal(ph[i]));
  endtask

  task automatic t_mirror;
    for (int i = 0; i < 1024; i++) begin
      ph[2*i]   = 1 + i * 16;
      ph[2*i+1] = 32768 - (1 + i * 16);
    end
    stream(2048, 0);
    for (int i = 0; i < 1024; i++)
      chk(got[2*i+1] == got[2*i], "R6 mirror", got[2*i+1], got[2*i]);
  endtask

  task automatic t_odd;
    for (int i = 0; i < 1024; i++) begin
      ph[2*i]   = (i * 31) % 32768;
      ph[2*i+1] = ph[2*i] + 32768;
    end
    stream(2048, 0);
    for (int i = 0; i < 1024; i++) begin
      int s = got[2*i] + got[2*i+1];
      chk(s == 0 || s == 1, "R7 odd symmetry", s, 0);
    end
  endtask

  task automatic t_backpressure;
    for (int i = 0; i < 2048; i++) ph[i] = (i * 97) % 65536;
    stream(2048, 1);
    for (int i = 0; i < 2048; i++)
      chk(absdiff(got[i], ideal(ph[i])) <= 2, "R3 result under stalls", got[i], ideal(ph[i]));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_exact();
    t_throughput();
    t_mirror();
    t_odd();
    t_backpressure();
    t_sweep();
    finished = 1;
    summary();
    $finish;
  end
endmodule